// File: doc/BRIEF.md
# Address-Latched Multicart Bank Mapper

This block sits between a game console's CPU and PPU buses and the ROM arrays of a multi-game cartridge. Whenever the CPU writes anywhere in the top half of its 64 KiB space, the block keeps a copy of selected bits of the write *address*. Nothing is taken from the data bus. The latched value is a style bit, a mirroring bit and a 3-bit bank number. From these it forms the upper PRG ROM address lines, the upper CHR ROM address lines and the CIRAM A10 select for nametable mirroring.

The single bank number feeds PRG and CHR at the same time. In the split style, one 16 KiB program bank appears twice, at $8000 and at $C000. In the wide style, the two upper bank bits select a 32 KiB program bank, and CPU A14 passes straight through. The character side always uses the full 3-bit value as an 8 KiB bank.

The block also answers a narrow family of CPU reads in the $6000 region. On those reads it drives only data bit 7, and drives it high. Every other bit, and every other read, leaves the bus undriven. The reset input is asynchronous and active low. Its release is synchronised to the CPU clock. Reset clears the latch.

Top module: `addr_latch_mapper`

## Requirements
- R1: While reset is low, and after it is released with no qualifying write, the latch is all zero. So prg_hi = 000 for either CPU A14, chr_hi = 000, and ciram_a10 follows ppu_a10.
- R2: A clock edge with cpu_wr = 1 and cpu_addr[15] = 1 stores three fields, which take effect right after that edge. cpu_addr[14] becomes the style bit, cpu_addr[3] becomes the mirroring bit, and cpu_addr[2:0] becomes the bank number. The other address bits have no effect.
- R3: A clock edge with cpu_wr = 1 and cpu_addr[15] = 0 leaves prg_hi, chr_hi and the mirroring choice unchanged.
- R4: With style 0, prg_hi equals the 3-bit bank whatever the value of cpu_addr[14].
- R5: With style 1, prg_hi[2:1] equals bank[2:1] and prg_hi[0] equals cpu_addr[14].
- R6: chr_hi equals the 3-bit bank in both styles.
- R7: With mirroring bit 0, ciram_a10 equals ppu_a10. With mirroring bit 1, ciram_a10 equals ppu_a11.
- R8: When cpu_rd = 1 and (cpu_addr AND $E010) = $6000, dbus_oe = 8'h80 and dbus_out[7] = 1. This holds for example at $6000 and $7FEF.
- R9: On every other read, and whenever cpu_rd = 0, dbus_oe = 8'h00 and dbus_out = 8'h00. This includes $6010, $7FFF and $8000. Bits 6..0 of dbus_oe are never set.
- R10: A cycle with both strobes high is decoded for each function on its own terms. With address $6000, the bit-7 drive occurs and the latch does not change. With an address at or above $8000, the latch loads and nothing is driven.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_addr | input | 16 | CPU address bus |
| cpu_wr | input | 1 | CPU write strobe |
| cpu_rd | input | 1 | CPU read strobe |
| ppu_a10 | input | 1 | PPU address line 10 |
| ppu_a11 | input | 1 | PPU address line 11 |
| prg_hi | output | 3 | PRG ROM address lines A16..A14 |
| chr_hi | output | 3 | CHR ROM address lines A15..A13 |
| ciram_a10 | output | 1 | Nametable RAM A10 select |
| dbus_oe | output | 8 | Per-bit CPU data drive enable |
| dbus_out | output | 8 | CPU data value where enabled |

## Verification
A read decode and a latch update can both be requested in the same cycle, because both strobes may be high at once. The bench provokes this in two ways. First, it raises both strobes on $6000: the bit-7 drive must appear, and chr_hi and prg_hi must show the earlier bank afterwards. Second, it raises both strobes on an address above $8000: the bus must stay undriven, and the new bank and style must appear after the edge. Around this, an exhaustive sweep covers every style, mirroring and bank value, and a second sweep covers all 65536 read addresses against the masked compare.

// File: rtl/mapper_pkg.sv
`timescale 1ns/1ps
package mapper_pkg;
  parameter int CPU_AW     = 16;
  parameter int BANK_W     = 3;
  parameter int DATA_W     = 8;
  parameter int SEL_BIT    = 15;
  parameter int STYLE_BIT  = 14;
  parameter int MIRROR_BIT = 3;
  parameter int BANK_LSB   = 0;
  parameter logic [CPU_AW-1:0] RD_MASK  = 16'hE010;
  parameter logic [CPU_AW-1:0] RD_MATCH = 16'h6000;
  parameter logic [DATA_W-1:0] RD_DRIVE = 8'h80;
  parameter logic [DATA_W-1:0] RD_VALUE = 8'h80;

  typedef struct packed {
    logic              wide;
    logic              horiz;
    logic [BANK_W-1:0] bank;
  } map_cfg_t;
endpackage

// File: rtl/mapper_rst_sync.sv
`timescale 1ns/1ps
module mapper_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) chain_q <= '0;
    else           chain_q <= chain_d;
  end

  assign rst_n_out = chain_q[STAGES-1];
endmodule

// File: rtl/mapper_bank_latch.sv
`timescale 1ns/1ps
module mapper_bank_latch
  import mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [CPU_AW-1:0] addr,
  output map_cfg_t          cfg_q
);
  logic     load_en;
  map_cfg_t cfg_d;
  logic     armed_q;

  always_comb begin
    load_en = wr & addr[SEL_BIT];
    cfg_d   = cfg_q;
    if (load_en) begin
      cfg_d.wide  = addr[STYLE_BIT];
      cfg_d.horiz = addr[MIRROR_BIT];
      cfg_d.bank  = addr[BANK_LSB +: BANK_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  // marks that one clocked cycle has passed since reset, for $past checks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed_q <= 1'b0;
    else        armed_q <= 1'b1;
  end

  // R2: a qualifying write leaves the address fields in the latch
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && $past(wr) && $past(addr[SEL_BIT]) |->
      (cfg_q.wide == $past(addr[STYLE_BIT])) &&
      (cfg_q.horiz == $past(addr[MIRROR_BIT])) &&
      (cfg_q.bank == $past(addr[BANK_LSB +: BANK_W])));

  // R3: without a qualifying write the latch holds
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && !($past(wr) && $past(addr[SEL_BIT])) |-> $stable(cfg_q));
endmodule

// File: rtl/mapper_addr_map.sv
`timescale 1ns/1ps
module mapper_addr_map
  import mapper_pkg::*;
(
  input  map_cfg_t          cfg,
  input  logic              cpu_a14,
  input  logic              ppu_a10,
  input  logic              ppu_a11,
  output logic [BANK_W-1:0] prg_hi,
  output logic [BANK_W-1:0] chr_hi,
  output logic              ciram_a10
);
  for (genvar i = 0; i < BANK_W; i++) begin : g_prg
    if (i == 0) begin : g_lsb
      assign prg_hi[i] = cfg.wide ? cpu_a14 : cfg.bank[i];
    end else begin : g_upper
      assign prg_hi[i] = cfg.bank[i];
    end
  end

  assign chr_hi    = cfg.bank;
  assign ciram_a10 = cfg.horiz ? ppu_a11 : ppu_a10;
endmodule

// File: rtl/mapper_read_decode.sv
`timescale 1ns/1ps
module mapper_read_decode
  import mapper_pkg::*;
(
  input  logic              rd,
  input  logic [CPU_AW-1:0] addr,
  output logic [DATA_W-1:0] oe,
  output logic [DATA_W-1:0] dout
);
  logic hit;

  assign hit = rd && ((addr & RD_MASK) == RD_MATCH);

  for (genvar i = 0; i < DATA_W; i++) begin : g_bit
    assign oe[i]   = hit & RD_DRIVE[i];
    assign dout[i] = oe[i] & RD_VALUE[i];
  end
endmodule

// File: rtl/addr_latch_mapper.sv
`timescale 1ns/1ps
module addr_latch_mapper
  import mapper_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic              cpu_wr,
  input  logic              cpu_rd,
  input  logic              ppu_a10,
  input  logic              ppu_a11,
  output logic [BANK_W-1:0] prg_hi,
  output logic [BANK_W-1:0] chr_hi,
  output logic              ciram_a10,
  output logic [DATA_W-1:0] dbus_oe,
  output logic [DATA_W-1:0] dbus_out
);
  logic     rst_n_s;
  map_cfg_t cfg;

  mapper_rst_sync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  mapper_bank_latch u_latch (
    .clk   (clk),
    .rst_n (rst_n_s),
    .wr    (cpu_wr),
    .addr  (cpu_addr),
    .cfg_q (cfg)
  );

  mapper_addr_map u_map (
    .cfg       (cfg),
    .cpu_a14   (cpu_addr[STYLE_BIT]),
    .ppu_a10   (ppu_a10),
    .ppu_a11   (ppu_a11),
    .prg_hi    (prg_hi),
    .chr_hi    (chr_hi),
    .ciram_a10 (ciram_a10)
  );

  mapper_read_decode u_rd (
    .rd   (cpu_rd),
    .addr (cpu_addr),
    .oe   (dbus_oe),
    .dout (dbus_out)
  );

  // R4: split style places one bank on both halves, so PRG matches CHR
  a_r4_split_same: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cfg.wide |-> (prg_hi == chr_hi));

  // R5: wide style passes CPU A14 through on the lowest PRG line
  a_r5_wide_a14: assert property (@(posedge clk) disable iff (!rst_n_s)
    cfg.wide |-> (prg_hi[0] == cpu_addr[STYLE_BIT]) &&
                 (prg_hi[BANK_W-1:1] == chr_hi[BANK_W-1:1]));

  // R9: no drive without a read strobe
  a_r9_needs_rd: assert property (@(posedge clk) disable iff (!rst_n_s)
    !cpu_rd |-> (dbus_oe == '0));

  // R8: only the top data bit is ever enabled, and it reads high
  a_r8_top_only: assert property (@(posedge clk) disable iff (!rst_n_s)
    $onehot0(dbus_oe) && (dbus_oe[DATA_W-2:0] == '0) &&
    (dbus_oe[DATA_W-1] == dbus_out[DATA_W-1]));

  // R9: reads at or above the bank-write window never drive
  a_r9_upper_quiet: assert property (@(posedge clk) disable iff (!rst_n_s)
    cpu_addr[SEL_BIT] |-> (dbus_oe == '0));
endmodule

// File: tb/addr_latch_mapper_bench.sv
`timescale 1ns/1ps
module addr_latch_mapper_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [15:0] cpu_addr;
  logic        cpu_wr, cpu_rd, ppu_a10, ppu_a11;
  logic [2:0]  prg_hi, chr_hi;
  logic        ciram_a10;
  logic [7:0]  dbus_oe, dbus_out;

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  addr_latch_mapper u_addr_latch_mapper (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_wr(cpu_wr),
    .cpu_rd(cpu_rd), .ppu_a10(ppu_a10), .ppu_a11(ppu_a11),
    .prg_hi(prg_hi), .chr_hi(chr_hi), .ciram_a10(ciram_a10),
    .dbus_oe(dbus_oe), .dbus_out(dbus_out)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_write(input logic [15:0] a, input logic rd);
    @(negedge clk);
    cpu_addr = a; cpu_wr = 1'b1; cpu_rd = rd;
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
  endtask

  // checks PRG for both CPU A14 values, CHR, and mirroring for all PPU combos
  task automatic chk_map(input string req, input bit s, input bit m, input logic [2:0] b);
    for (int h = 0; h < 2; h++) begin
      cpu_addr = h[0] ? 16'hC000 : 16'h8000;
      #0.5;
      chk({req, s ? " R5 prg" : " R4 prg"}, {5'd0, prg_hi},
          {5'd0, s ? {b[2:1], h[0]} : b});
    end
    chk({req, " R6 chr"}, {5'd0, chr_hi}, {5'd0, b});
    for (int p = 0; p < 4; p++) begin
      ppu_a10 = p[0]; ppu_a11 = p[1];
      #0.2;
      chk({req, " R7 ciram"}, {7'd0, ciram_a10}, {7'd0, m ? p[1] : p[0]});
    end
  endtask

  task automatic chk_read(input string req, input logic [15:0] a, input bit hit);
    cpu_addr = a; cpu_rd = 1'b1;
    #0.5;
    chk({req, " oe"}, dbus_oe, hit ? 8'h80 : 8'h00);
    chk({req, " out"}, dbus_out, hit ? 8'h80 : 8'h00);
    cpu_rd = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cpu_addr = 16'h0000; cpu_wr = 1'b0; cpu_rd = 1'b0;
    ppu_a10 = 1'b0; ppu_a11 = 1'b0;
    repeat (3) @(negedge clk);
    chk_map("R1 in reset", 1'b0, 1'b0, 3'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_map("R1 after release", 1'b0, 1'b0, 3'd0);

    // R2 exhaustive: style, mirroring and bank, with varied unused address bits
    for (int s = 0; s < 2; s++)
      for (int m = 0; m < 2; m++)
        for (int b = 0; b < 8; b++) begin
          logic [15:0] noise, wa;
          noise = 16'((b * 16'h0451 + s * 16'h1230 + m * 16'h0a70) & 16'h3FF0);
          wa = 16'h8000 | (s[0] ? 16'h4000 : 16'h0) | noise |
               (m[0] ? 16'h0008 : 16'h0) | 16'(b);
          do_write(wa, 1'b0);
          chk_map("R2 load", s[0], m[0], 3'(b));
          // R3: write below $8000 with different fields is ignored
          do_write(16'h7000 | (s[0] ? 16'h0 : 16'h4000) |
                   (m[0] ? 16'h0 : 16'h0008) | 16'(~b & 7), 1'b0);
          chk_map("R3 ignored", s[0], m[0], 3'(b));
        end

    // R8/R9 named boundaries
    chk_read("R8 $6000", 16'h6000, 1'b1);
    chk_read("R8 $7FEF", 16'h7FEF, 1'b1);
    chk_read("R9 $6010", 16'h6010, 1'b0);
    chk_read("R9 $7FFF", 16'h7FFF, 1'b0);
    chk_read("R9 $8000", 16'h8000, 1'b0);
    cpu_addr = 16'h6000; cpu_rd = 1'b0; #0.5;
    chk("R9 no strobe", dbus_oe, 8'h00);

    // R8/R9 full read-address sweep
    for (int a = 0; a < 65536; a++) begin
      logic [15:0] aa;
      aa = 16'(a);
      chk_read(((aa & 16'hE010) == 16'h6000) ? "R8 sweep" : "R9 sweep", aa,
               (aa & 16'hE010) == 16'h6000);
      #0.5;
    end

    // R10: both strobes high, read window address
    do_write(16'h8005, 1'b0);
    @(negedge clk);
    cpu_addr = 16'h6000; cpu_wr = 1'b1; cpu_rd = 1'b1;
    #0.5;
    chk("R10 drive during write", dbus_oe, 8'h80);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
    chk_map("R10 latch kept", 1'b0, 1'b0, 3'd5);
    // R10: both strobes high, bank window address
    @(negedge clk);
    cpu_addr = 16'hC00E; cpu_wr = 1'b1; cpu_rd = 1'b1;
    #0.5;
    chk("R10 no drive on bank write", dbus_oe, 8'h00);
    @(negedge clk);
    cpu_wr = 1'b0; cpu_rd = 1'b0;
    chk_map("R10 latch loaded", 1'b1, 1'b1, 3'd6);

    // R1: asynchronous reset in mid-run
    @(negedge clk);
    rst_n = 1'b0;
    #0.5;
    chk_map("R1 mid-run reset", 1'b0, 1'b0, 3'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk_map("R1 after second release", 1'b0, 1'b0, 3'd0);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #900000;
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule